// File: doc/BRIEF.md
# Three-operand logic and shift unit

This block is a registered execution unit for register-to-register operations of the form `a = b OP c`. Each operation is selected by an 8-bit group code and a 4-bit operation code. It covers bitwise logic, including the four implication operators. It covers shifts that fill vacated bits with zeros, ones or the sign, and it covers rotates. It also provides signed and unsigned maximum and minimum, and a three-way signed or unsigned compare.

An issuing pipeline presents one operation per cycle with `valid_in`. One clock later the unit returns the result together with a write-enable for the destination register. Codes outside the supported set, such as loads, stores, compare-jumps, multiply, divide and reserved slots, raise an illegal flag instead. For these codes the write-enable is withheld so the destination register is left untouched.

Top module: `logic_shift_unit`

## Requirements
- R1: Group 0x02, operation codes 0 to 5 give b AND c, b OR c, b XOR c, NOT(b AND c), NOT(b OR c) and NOT(b XOR c), in that code order.
- R2: Group 0x02, operation codes 6 to 9 give ~b & c, b & ~c, ~b | c and b | ~c, in that code order.
- R3: Group 0x03 shift codes:
  - Codes 0 and 2 shift b left and fill with zeros.
  - Code 1 shifts right and fills with b's sign bit.
  - Code 3 shifts right and fills with zeros.
  - Code 4 shifts left and fills with ones.
  - Code 5 shifts right and fills with ones.
  - The amount is the low 5 bits of c, and an amount of 0 returns b unchanged.
- R4: Group 0x03, code 6 rotates b left and code 7 rotates b right by the low 5 bits of c.
- R5: Group 0x01, codes 0 to 3 give signed maximum, unsigned maximum, signed minimum and unsigned minimum of b and c.
- R6: Group 0x00, code 4 (signed) and code 5 (unsigned) return 1 when b > c, 0 when b == c and all-ones when b < c.
- R7: Any other code is illegal. This includes group 0x00 codes other than 4 and 5, group 0x01 codes 4 and up, group 0x02 codes 0xA and up, group 0x03 codes 8 and up, and every other group. For an illegal code, the output stage shows illegal_out=1, wr_en_out=0 and result_out=0.
- R8: valid_out follows valid_in by exactly one clock. A legal operation raises wr_en_out with valid_out. A cycle without valid_in leaves valid_out, wr_en_out and illegal_out at 0 and holds result_out.
- R9: While reset is held, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | An operation is presented this cycle |
| group_in | input | 8 | Operation group code |
| op_in | input | 4 | Operation code within the group |
| b_in | input | WIDTH | First source operand |
| c_in | input | WIDTH | Second source operand / shift amount |
| valid_out | output | 1 | Output stage holds a completed operation |
| result_out | output | WIDTH | Operation result |
| wr_en_out | output | 1 | Write the result to the destination |
| illegal_out | output | 1 | The completed operation code was illegal |

## Verification
Two events can fall in the same cycle:
- the output stage presenting the previous operation's result, and
- the input capturing a new operation, which may be legal or illegal.

The bench provokes this by issuing operations back to back with no idle cycles. It interleaves illegal codes between legal ones, so that the write-enable and the illegal flag must drop and rise from one cycle to the next. A scoreboard queue pairs each result with its own issue in order. An idle window checks that result_out holds while valid_out stays low.

// File: rtl/logic_shift_unit.sv
module logic_shift_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_in,
  input  logic [7:0]       group_in,
  input  logic [3:0]       op_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [WIDTH-1:0] c_in,
  output logic             valid_out,
  output logic [WIDTH-1:0] result_out,
  output logic             wr_en_out,
  output logic             illegal_out
);
  localparam int SHW = $clog2(WIDTH);
  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [SHW-1:0]     amt;
  logic [2*WIDTH-1:0] dbl_l, dbl_r;
  logic [WIDTH-1:0]   shl, shr, sar, rol, ror, fill_l, fill_r;
  logic               lt_s, lt_u;
  logic [WIDTH-1:0]   res_n;
  logic               ill_n;

  assign amt    = c_in[SHW-1:0];
  assign shl    = b_in << amt;
  assign shr    = b_in >> amt;
  assign sar    = WIDTH'($signed(b_in) >>> amt);
  assign fill_l = ~(ONES << amt);
  assign fill_r = ~(ONES >> amt);
  assign dbl_l  = {b_in, b_in} << amt;
  assign dbl_r  = {b_in, b_in} >> amt;
  assign rol    = dbl_l[2*WIDTH-1:WIDTH];
  assign ror    = dbl_r[WIDTH-1:0];
  assign lt_s   = $signed(b_in) < $signed(c_in);
  assign lt_u   = b_in < c_in;

  always_comb begin
    res_n = '0;
    ill_n = 1'b0;
    case (group_in)
      8'h00: case (op_in)
        4'h4:    res_n = lt_s ? ONES : (b_in == c_in) ? '0 : ONE;
        4'h5:    res_n = lt_u ? ONES : (b_in == c_in) ? '0 : ONE;
        default: ill_n = 1'b1;
      endcase
      8'h01: case (op_in)
        4'h0:    res_n = lt_s ? c_in : b_in;
        4'h1:    res_n = lt_u ? c_in : b_in;
        4'h2:    res_n = lt_s ? b_in : c_in;
        4'h3:    res_n = lt_u ? b_in : c_in;
        default: ill_n = 1'b1;
      endcase
      8'h02: case (op_in)
        4'h0:    res_n = b_in & c_in;
        4'h1:    res_n = b_in | c_in;
        4'h2:    res_n = b_in ^ c_in;
        4'h3:    res_n = ~(b_in & c_in);
        4'h4:    res_n = ~(b_in | c_in);
        4'h5:    res_n = ~(b_in ^ c_in);
        4'h6:    res_n = ~b_in & c_in;
        4'h7:    res_n = b_in & ~c_in;
        4'h8:    res_n = ~b_in | c_in;
        4'h9:    res_n = b_in | ~c_in;
        default: ill_n = 1'b1;
      endcase
      8'h03: case (op_in)
        4'h0, 4'h2: res_n = shl;
        4'h1:    res_n = sar;
        4'h3:    res_n = shr;
        4'h4:    res_n = shl | fill_l;
        4'h5:    res_n = shr | fill_r;
        4'h6:    res_n = rol;
        4'h7:    res_n = ror;
        default: ill_n = 1'b1;
      endcase
      default: ill_n = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_out   <= 1'b0;
      wr_en_out   <= 1'b0;
      illegal_out <= 1'b0;
      result_out  <= '0;
    end else begin
      valid_out   <= valid_in;
      wr_en_out   <= valid_in && !ill_n;
      illegal_out <= valid_in && ill_n;
      if (valid_in) result_out <= ill_n ? '0 : res_n;
    end
  end

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> (!valid_out && !wr_en_out && !illegal_out && $stable(result_out)));
  p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_out |-> (!wr_en_out && valid_out && result_out == '0));
  p_and_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && group_in == 8'h02 && op_in == 4'h0) |=>
      (result_out == ($past(b_in) & $past(c_in))));
  p_zero_amount_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && group_in == 8'h03 && op_in < 4'h8 && c_in[SHW-1:0] == '0) |=>
      (result_out == $past(b_in)));
  p_cmp_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && group_in == 8'h00 && (op_in == 4'h4 || op_in == 4'h5)) |=>
      (result_out == ONE || result_out == '0 || result_out == ONES));
  p_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && group_in == 8'h01 && op_in == 4'h1) |=>
      (result_out >= $past(b_in) && result_out >= $past(c_in)));
endmodule

// File: tb/sim_logic_shift_unit.sv
module sim_logic_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [7:0]  group_in = '0;
  logic [3:0]  op_in = '0;
  logic [31:0] b_in = '0, c_in = '0;
  logic        valid_out, wr_en_out, illegal_out;
  logic [31:0] result_out;

  int checks = 0, failures = 0;
  logic [31:0] q_res[$];
  logic        q_ill[$];
  string       q_tag[$];
  logic        done = 1'b0;

  always #5 clk = ~clk;

  logic_shift_unit #(.WIDTH(32)) u0 (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .group_in(group_in),
    .op_in(op_in), .b_in(b_in), .c_in(c_in), .valid_out(valid_out),
    .result_out(result_out), .wr_en_out(wr_en_out), .illegal_out(illegal_out));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] shift_model(input logic [31:0] b, input int s,
                                              input bit left, input logic fill);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (left) r[i] = (i >= s) ? b[i-s] : fill;
      else      r[i] = (i + s < 32) ? b[i+s] : fill;
    end
    return r;
  endfunction

  function automatic logic [31:0] rot_model(input logic [31:0] b, input int s, input bit left);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (left) r[(i + s) % 32] = b[i];
      else      r[i] = b[(i + s) % 32];
    end
    return r;
  endfunction

  task automatic model(input logic [7:0] g, input logic [3:0] o, input logic [31:0] b,
                       input logic [31:0] c, output logic [31:0] r, output logic ill,
                       output string tag);
    int s;
    longint sb, sc;
    s = int'(c[4:0]);
    sb = longint'($signed(b));
    sc = longint'($signed(c));
    r = 32'h0; ill = 1'b0; tag = "R7";
    if (g == 8'h02 && o <= 4'h5) begin
      tag = "R1";
      case (o)
        4'h0: r = b & c;   4'h1: r = b | c;   4'h2: r = b ^ c;
        4'h3: r = ~(b & c); 4'h4: r = ~(b | c); default: r = ~(b ^ c);
      endcase
    end else if (g == 8'h02 && o <= 4'h9) begin
      tag = "R2";
      case (o)
        4'h6: r = ~b & c; 4'h7: r = b & ~c; 4'h8: r = ~b | c; default: r = b | ~c;
      endcase
    end else if (g == 8'h03 && o <= 4'h5) begin
      tag = "R3";
      case (o)
        4'h0, 4'h2: r = shift_model(b, s, 1'b1, 1'b0);
        4'h1: r = shift_model(b, s, 1'b0, b[31]);
        4'h3: r = shift_model(b, s, 1'b0, 1'b0);
        4'h4: r = shift_model(b, s, 1'b1, 1'b1);
        default: r = shift_model(b, s, 1'b0, 1'b1);
      endcase
    end else if (g == 8'h03 && o <= 4'h7) begin
      tag = "R4";
      r = rot_model(b, s, o == 4'h6);
    end else if (g == 8'h01 && o <= 4'h3) begin
      tag = "R5";
      case (o)
        4'h0: r = (sb > sc) ? b : c;
        4'h1: r = (b > c) ? b : c;
        4'h2: r = (sb < sc) ? b : c;
        default: r = (b < c) ? b : c;
      endcase
    end else if (g == 8'h00 && (o == 4'h4 || o == 4'h5)) begin
      tag = "R6";
      if (o == 4'h4) r = (sb > sc) ? 32'd1 : (sb == sc) ? 32'd0 : 32'hFFFF_FFFF;
      else           r = (b > c) ? 32'd1 : (b == c) ? 32'd0 : 32'hFFFF_FFFF;
    end else ill = 1'b1;
  endtask

  task automatic issue(input logic [7:0] g, input logic [3:0] o,
                       input logic [31:0] b, input logic [31:0] c);
    logic [31:0] r; logic ill; string tag;
    model(g, o, b, c, r, ill, tag);
    @(negedge clk);
    valid_in = 1'b1; group_in = g; op_in = o; b_in = b; c_in = c;
    q_res.push_back(r); q_ill.push_back(ill); q_tag.push_back(tag);
  endtask

  // monitor: samples 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (rst_n && valid_out) begin
      if (q_res.size() == 0) check("R8 unexpected valid_out", 32'd1, 32'd0);
      else begin
        logic [31:0] r; logic ill; string tag;
        r = q_res.pop_front(); ill = q_ill.pop_front(); tag = q_tag.pop_front();
        check(tag, result_out, r);
        check({tag, " R8 write-enable"}, {31'd0, wr_en_out}, {31'd0, !ill});
        check({tag, " illegal flag"}, {31'd0, illegal_out}, {31'd0, ill});
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset valid_out", {31'd0, valid_out}, 32'd0);
    check("R9 reset wr_en_out", {31'd0, wr_en_out}, 32'd0);
    check("R9 reset illegal_out", {31'd0, illegal_out}, 32'd0);
    check("R9 reset result_out", result_out, 32'd0);
    rst_n = 1'b1;

    for (int o = 0; o < 16; o++) issue(8'h02, 4'(o), 32'hF0F0_1234, 32'h0FF0_5678);
    for (int o = 0; o < 16; o++) issue(8'h03, 4'(o), 32'h8123_4567, 32'd4);
    for (int o = 0; o < 8; o++)  issue(8'h03, 4'(o), 32'h8123_4567, 32'd0);
    for (int o = 0; o < 8; o++)  issue(8'h03, 4'(o), 32'h8123_4567, 32'd33);
    for (int o = 0; o < 8; o++)  issue(8'h03, 4'(o), 32'h8000_0001, 32'd31);
    for (int o = 0; o < 8; o++)  issue(8'h01, 4'(o), 32'hFFFF_FFFB, 32'd3);
    for (int o = 0; o < 4; o++)  issue(8'h01, 4'(o), 32'd7, 32'd7);
    for (int o = 0; o < 16; o++) issue(8'h00, 4'(o), 32'hFFFF_FFFB, 32'd3);
    issue(8'h00, 4'h4, 32'd9, 32'd9);
    issue(8'h00, 4'h5, 32'd2, 32'd9);
    issue(8'h00, 4'h4, 32'd9, 32'd2);
    issue(8'h04, 4'h0, 32'd1, 32'd2);
    issue(8'h02, 4'h0, 32'hFFFF_0000, 32'h0F0F_0F0F);
    issue(8'hFF, 4'hF, 32'd1, 32'd2);
    issue(8'h02, 4'h9, 32'h0000_FFFF, 32'h1234_5678);
    issue(8'h05, 4'h2, 32'd5, 32'd6);
    issue(8'h03, 4'h6, 32'h1234_5678, 32'd8);

    @(negedge clk);
    valid_in = 1'b0; b_in = 32'hDEAD_BEEF; c_in = 32'd1; group_in = 8'h02;
    repeat (2) @(negedge clk);
    check("R8 idle result holds", result_out, rot_model(32'h1234_5678, 8, 1'b1));
    check("R8 idle valid_out low", {31'd0, valid_out}, 32'd0);
    check("R8 idle wr_en_out low", {31'd0, wr_en_out}, 32'd0);
    check("R8 idle illegal_out low", {31'd0, illegal_out}, 32'd0);
    check("R8 scoreboard drained", q_res.size(), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule